// File: doc/BRIEF.md
# Bidirectional Six-Mode Barrel Shifter

This block shifts or rotates a WIDTH-bit word by a signed distance in a single combinational pass, and registers the result. A 3-bit operation code selects the class and the nominal direction. The class is logical, arithmetic or rotate, and the direction is left or right. The sign of the distance can reverse that direction. A negative distance performs the opposite-direction operation of the same class, using the magnitude of the distance.

Bits that a shift vacates are filled according to the class. Logical shifts fill with zero. An arithmetic left shift repeats the original least significant bit into the vacated low positions. An arithmetic right shift repeats the original most significant bit into the vacated high positions. A rotate brings the bits that leave one end back in at the other end, and its distance is taken modulo WIDTH. Each result is captured on the clock edge that sees `in_valid` high, and appears with `out_valid` one cycle later.

Top module: `shift_unit`

## Requirements
- R1: Opcode 0 shifts left and opcode 1 shifts right, filling vacated positions with 0. For WIDTH 8, 10010110 shifted right by 2 gives 00100101.
- R2: Opcode 3 shifts right and fills vacated high positions with the original bit WIDTH-1. For WIDTH 6, 101001 shifted this way by 2 gives 111010.
- R3: Opcode 2 shifts left and fills vacated low positions with the original bit 0. For WIDTH 6, 101001 shifted this way by 2 gives 100111.
- R4: Opcode 4 rotates left and opcode 5 rotates right, by the distance modulo WIDTH. Bit i moves to bit (i+d) mod WIDTH for a left rotate and to bit (i-d) mod WIDTH for a right rotate.
- R5: The distance `in_amt` is two's complement. A negative value performs the opposite direction of the same class with magnitude -in_amt, taking the fill of that opposite direction. For WIDTH 8, opcode 1 with -2 applied to 10010110 gives 01011000.
- R6: For a non-rotate opcode whose distance magnitude is WIDTH or more, every result bit equals the fill value of the effective direction.
- R7: Opcodes 6 and 7 return the data unchanged, and so does any opcode with distance 0.
- R8: When `in_valid` is high at a rising edge, the result of that input appears on `out_data` and `out_valid` is high after that edge. When `in_valid` is low, `out_valid` falls and `out_data` holds its last value.
- R9: A synchronous active-high `rst` drives `out_valid` and `out_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word, distance and opcode are valid |
| in_data | input | WIDTH | Word to shift |
| in_amt | input | AMT_W = clog2(WIDTH)+2 | Signed shift distance |
| in_op | input | 3 | Operation code, 0 to 7 |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | WIDTH | Registered result |

## Verification
The hardest cases to reach are the extreme negative distance, whose magnitude of 2^(AMT_W-1) does not fit as a positive value of the same width, and reversed arithmetic shifts, whose fill bit comes from the opposite end of the word. The stimulus does not aim at these cases one by one. It sweeps every data word, every representable distance and every opcode at WIDTH 8, so both cases are covered along with distances that wrap past WIDTH. The bench computes each expected bit from a source index by integer arithmetic.

// File: rtl/shift_pkg.sv
package shift_pkg;
    typedef enum logic [2:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_THR6 = 3'd6,
        OP_THR7 = 3'd7
    } shift_op_e;

    typedef enum logic [1:0] {
        KIND_LOGIC = 2'd0,
        KIND_ARITH = 2'd1,
        KIND_ROT   = 2'd2,
        KIND_PASS  = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
#(
    parameter int AMT_W = 5
) (
    input  logic [2:0]       op,
    input  logic [AMT_W-1:0] amt,
    output shift_kind_e      kind,
    output logic             go_left,
    output logic [AMT_W-1:0] mag
);
    logic nominal_left;
    logic negative;

    always_comb begin
        negative = amt[AMT_W-1];
        // Two's complement negate; the most negative value maps to 2^(AMT_W-1) unsigned.
        mag      = negative ? (~amt + 1'b1) : amt;
        case (shift_op_e'(op))
            OP_LSL:  begin kind = KIND_LOGIC; nominal_left = 1'b1; end
            OP_LSR:  begin kind = KIND_LOGIC; nominal_left = 1'b0; end
            OP_ASL:  begin kind = KIND_ARITH; nominal_left = 1'b1; end
            OP_ASR:  begin kind = KIND_ARITH; nominal_left = 1'b0; end
            OP_ROL:  begin kind = KIND_ROT;   nominal_left = 1'b1; end
            OP_ROR:  begin kind = KIND_ROT;   nominal_left = 1'b0; end
            default: begin kind = KIND_PASS;  nominal_left = 1'b1; end
        endcase
        go_left = nominal_left ^ negative;
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int MAG_W = 5
) (
    input  logic [WIDTH-1:0] data,
    input  shift_kind_e      kind,
    input  logic             go_left,
    input  logic [MAG_W-1:0] mag,
    output logic [WIDTH-1:0] res
);
    // Right operations run as left operations on the bit-reversed word.
    logic [WIDTH-1:0]            work;
    logic                        fill;
    logic [MAG_W:0][WIDTH-1:0]   sh_stage;
    logic [MAG_W:0][WIDTH-1:0]   rot_stage;
    logic [WIDTH-1:0]            oriented;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            work[i] = go_left ? data[i] : data[WIDTH-1-i];
        end
        // After reversal, work[0] is the bit an arithmetic shift must repeat.
        fill = (kind == KIND_ARITH) & work[0];
    end

    assign sh_stage[0]  = work;
    assign rot_stage[0] = work;

    for (genvar k = 0; k < MAG_W; k++) begin : g_stage
        localparam int SH_STEP  = 1 << k;
        localparam int ROT_STEP = (1 << k) % WIDTH;

        if (SH_STEP >= WIDTH) begin : g_sat
            assign sh_stage[k+1] = mag[k] ? {WIDTH{fill}} : sh_stage[k];
        end else begin : g_sh
            assign sh_stage[k+1] = mag[k]
                ? {sh_stage[k][WIDTH-1-SH_STEP:0], {SH_STEP{fill}}}
                : sh_stage[k];
        end

        if (ROT_STEP == 0) begin : g_rot_id
            assign rot_stage[k+1] = rot_stage[k];
        end else begin : g_rot
            assign rot_stage[k+1] = mag[k]
                ? {rot_stage[k][WIDTH-1-ROT_STEP:0], rot_stage[k][WIDTH-1:WIDTH-ROT_STEP]}
                : rot_stage[k];
        end
    end

    always_comb begin
        oriented = (kind == KIND_ROT) ? rot_stage[MAG_W] : sh_stage[MAG_W];
        if (kind == KIND_PASS) begin
            res = data;
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                res[i] = go_left ? oriented[i] : oriented[WIDTH-1-i];
            end
        end
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH) + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    input  logic [AMT_W-1:0] in_amt,
    input  logic [2:0]       in_op,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } out_state_t;

    shift_kind_e      kind;
    logic             go_left;
    logic [AMT_W-1:0] mag;
    logic [WIDTH-1:0] shifted;
    out_state_t       state_d;
    out_state_t       state_q;

    shift_decode #(.AMT_W(AMT_W)) u_decode (
        .op      (in_op),
        .amt     (in_amt),
        .kind    (kind),
        .go_left (go_left),
        .mag     (mag)
    );

    shift_core #(.WIDTH(WIDTH), .MAG_W(AMT_W)) u_core (
        .data    (in_data),
        .kind    (kind),
        .go_left (go_left),
        .mag     (mag),
        .res     (shifted)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_data  = state_q.data;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R8
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R8
    AST_THROUGH_OPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b11) |=> out_data == $past(in_data)); // R7
    AST_ZERO_DIST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amt == '0) |=> out_data == $past(in_data)); // R7
    AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b10)
        |=> $countones(out_data) == $countones($past(in_data))); // R4
    AST_LOGIC_SAT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b00 && (32'(mag) >= WIDTH))
        |=> out_data == '0); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R9
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
    localparam int WIDTH = 8;
    localparam int AMT_W = $clog2(WIDTH) + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic [AMT_W-1:0] in_amt = '0;
    logic [2:0]       in_op = '0;
    logic             out_valid;
    logic [WIDTH-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shift_unit #(.WIDTH(WIDTH)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_amt    (in_amt),
        .in_op     (in_op),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [WIDTH-1:0] model(logic [WIDTH-1:0] d, int a, int op);
        logic [WIDTH-1:0] r;
        bit left;
        int m, src;
        logic f;
        if (op >= 6 || a == 0) return d;
        left = ((op % 2) == 0) ^ (a < 0);
        m = (a < 0) ? -a : a;
        if (op == 2 || op == 3) f = left ? d[0] : d[WIDTH-1];
        else f = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            src = left ? i - m : i + m;
            if (op >= 4) r[i] = d[((src % WIDTH) + WIDTH) % WIDTH];
            else if (src >= 0 && src < WIDTH) r[i] = d[src];
            else r[i] = f;
        end
        return r;
    endfunction

    function automatic string tag_of(int a, int op);
        if (op >= 6 || a == 0) return "R7";
        if (a <= -WIDTH || a >= WIDTH) begin
            if (op < 4) return "R6";
        end
        if (a < 0) return "R5";
        case (op)
            0, 1: return "R1";
            2: return "R3";
            3: return "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        logic [WIDTH-1:0] last;
        repeat (2) @(negedge clk);
        check("R9", {7'b0, out_valid}, '0);
        check("R9", out_data, '0);
        rst = 1'b0;

        // Worked examples at WIDTH 8
        in_valid = 1'b1; in_data = 8'b10010110; in_op = 3'd1; in_amt = 5'sd2;
        @(negedge clk);
        check("R1", out_data, 8'b00100101);
        check("R8", {7'b0, out_valid}, 8'd1);
        in_amt = -5'sd2;
        @(negedge clk);
        check("R5", out_data, 8'b01011000);

        // Exhaustive sweep
        for (int op = 0; op < 8; op++) begin
            for (int a = -(1 << (AMT_W-1)); a < (1 << (AMT_W-1)); a++) begin
                for (int d = 0; d < (1 << WIDTH); d++) begin
                    in_valid = 1'b1;
                    in_data  = WIDTH'(d);
                    in_amt   = AMT_W'(a);
                    in_op    = 3'(op);
                    @(negedge clk);
                    check(tag_of(a, op), out_data, model(WIDTH'(d), a, op));
                end
            end
        end

        // Idle cycles: output holds, valid drops (R8)
        last = out_data;
        in_valid = 1'b0; in_data = ~last; in_op = 3'd4; in_amt = 5'sd3;
        @(negedge clk);
        check("R8", {7'b0, out_valid}, '0);
        check("R8", out_data, last);
        @(negedge clk);
        check("R8", out_data, last);

        // Reset mid-run clears (R9)
        in_valid = 1'b1; in_data = 8'hA5; in_op = 3'd6; in_amt = '0;
        @(negedge clk);
        check("R7", out_data, 8'hA5);
        rst = 1'b1;
        @(negedge clk);
        check("R9", {7'b0, out_valid}, '0);
        check("R9", out_data, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule